// File: doc/BRIEF.md
# Prefix-Operand Instruction Framer

This block sits between an instruction fetch unit and the decoder of a small 8/16-bit core. It takes opcode bytes one at a time and groups them into whole instructions. An instruction is one of two kinds:

- A basic instruction, which starts with an ordinary opcode byte and may carry immediate bytes.
- An extended instruction, which starts with a prefix byte. The prefix names the addressing mode of the first operand and may bring its own displacement byte. The operation byte comes after that, and then any immediate bytes.

For each instruction the block presents these fields, held under a valid strobe until the consumer takes them:

- a flag that says which kind it is
- the prefix code
- the displacement
- the operation byte
- the immediate
- the total byte count

Both edges follow valid/ready rules. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. A framed instruction moves only in a cycle where `out_valid` and `out_ready` are both high. While an instruction is held, `in_ready` stays low, so the fetch side is stalled for that whole time. `out_valid` never drops on its own.

The `flush` pin is synchronous. It discards any partial instruction and any held instruction, and framing starts again on the next accepted byte. A byte offered in the same cycle as `flush` is not taken.

Top module: `insn_framer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A first byte in the range 0xE0..0xFE starts an extended instruction and sets `out_ext`=1. Any other first byte is a basic opcode with `out_ext`=0. The bytes that follow a basic opcode are set by its value: 0x20..0x3F takes one immediate byte, 0x40..0x4F takes two, and every other value takes none.
- R3: A prefix whose low nibble is 4..7 (0xE4..0xE7 and 0xF4..0xF7) is followed by exactly one displacement byte, which appears on `out_disp`. Every other prefix is followed directly by the operation byte.
- R4: In an extended instruction, an operation byte of 0x68..0x6F takes one immediate byte, 0x38..0x3F takes two, and any other value takes none.
- R5: `out_imm` holds the first immediate byte in bits 7:0 and the second in bits 15:8. Fields that the instruction does not use read as 0, including `out_prefix` and `out_disp` of a basic instruction. `out_len` gives the total byte count, from 1 to 5.
- R6: The stream F4 7F 68 05 frames as one extended instruction with prefix 0xF4, displacement 0x7F, operation 0x68, immediate 0x0005 and length 4.
- R7: Once `out_valid` rises it stays high, with every output field unchanged, until a cycle with `out_ready` high or `flush` high.
- R8: `in_ready` is low whenever `out_valid` is high, so no byte is taken while an instruction is held. After the instruction is accepted, `out_valid` falls and `in_ready` rises on the next cycle.
- R9: A cycle with `flush` high discards any partial or held instruction. On the next cycle `out_valid` is 0 and `in_ready` is 1, and the next byte is treated as a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of partial or held instruction |
| in_valid | input | 1 | Fetch byte valid |
| in_ready | output | 1 | Framer can take a byte |
| in_data | input | 8 | Fetch byte |
| out_valid | output | 1 | Framed instruction available |
| out_ready | input | 1 | Consumer takes the instruction |
| out_ext | output | 1 | 1 for a prefixed instruction |
| out_prefix | output | 8 | Prefix byte, 0 for basic |
| out_disp | output | 8 | Displacement byte, 0 if none |
| out_opcode | output | 8 | Operation byte |
| out_imm | output | 16 | Immediate, first byte in the low half |
| out_len | output | 3 | Total length in bytes (1..5) |

## Verification
The bench builds the block with its default prefix window, 0xE0 through 0xFE. With that window every prefix code can be drawn at random. It also makes the window edges reachable as directed cases: 0xDF and 0xFF frame as basic, while 0xE0 and 0xFE frame as extended. The longest form is reached with a zero-page prefix followed by a two-byte immediate operation, which gives 5 bytes. Random gaps on the input and random back-pressure on the output exercise the stall and hold rules. Directed flushes cover both a partial instruction and a held one.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int BYTE_W    = 8;
  localparam int IMM_BYTES = 2;
  localparam int IMM_W     = BYTE_W * IMM_BYTES;
  localparam int MAX_LEN   = 5;
  localparam int LEN_W     = $clog2(MAX_LEN + 1);
  localparam int CNT_W     = 2;
  localparam int IDX_W     = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;

  typedef enum logic [2:0] {
    ST_FIRST = 3'd0,
    ST_DISP  = 3'd1,
    ST_OP    = 3'd2,
    ST_IMM   = 3'd3,
    ST_HOLD  = 3'd4
  } fr_state_e;

  typedef struct packed {
    logic              ext;
    logic [BYTE_W-1:0] pfx;
    logic [BYTE_W-1:0] disp;
    logic [BYTE_W-1:0] opc;
    logic [IMM_W-1:0]  imm;
    logic [LEN_W-1:0]  len;
  } fr_insn_t;
endpackage

// File: rtl/framer_len_lut.sv
module framer_len_lut
  import framer_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PFX_FIRST = 8'hE0,
  parameter logic [BYTE_W-1:0] PFX_LAST  = 8'hFE
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic              is_pfx_o,
  output logic [CNT_W-1:0]  pfx_cnt_o,
  output logic [CNT_W-1:0]  ext_cnt_o,
  output logic [CNT_W-1:0]  base_cnt_o
);
  // prefix window
  assign is_pfx_o = (byte_i >= PFX_FIRST) && (byte_i <= PFX_LAST);

  // displacement-carrying prefixes: low nibble 4..7
  always_comb begin
    pfx_cnt_o = '0;
    if (byte_i[3:2] == 2'b01) pfx_cnt_o = CNT_W'(1);
  end

  // immediates behind an operation byte of an extended instruction
  always_comb begin
    case (byte_i[7:3])
      5'b01101: ext_cnt_o = CNT_W'(1);
      5'b00111: ext_cnt_o = CNT_W'(2);
      default:  ext_cnt_o = '0;
    endcase
  end

  // immediates behind a basic opcode
  always_comb begin
    case (byte_i[7:4])
      4'h2, 4'h3: base_cnt_o = CNT_W'(1);
      4'h4:       base_cnt_o = CNT_W'(2);
      default:    base_cnt_o = '0;
    endcase
  end
endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fire,
  input  logic             take,
  input  logic             is_pfx,
  input  logic [CNT_W-1:0] pfx_cnt,
  input  logic [CNT_W-1:0] ext_cnt,
  input  logic [CNT_W-1:0] base_cnt,
  output fr_state_e        state_o,
  output logic [IDX_W-1:0] idx_o
);
  fr_state_e        state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    idx_d   = idx_q;
    if (flush) begin
      state_d = ST_FIRST;
      rem_d   = '0;
      idx_d   = '0;
    end else begin
      case (state_q)
        ST_FIRST: if (fire) begin
          idx_d = '0;
          if (is_pfx) begin
            if (pfx_cnt != '0) begin
              state_d = ST_DISP;
              rem_d   = pfx_cnt;
            end else begin
              state_d = ST_OP;
            end
          end else if (base_cnt != '0) begin
            state_d = ST_IMM;
            rem_d   = base_cnt;
          end else begin
            state_d = ST_HOLD;
          end
        end
        ST_DISP: if (fire) begin
          rem_d = rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) state_d = ST_OP;
        end
        ST_OP: if (fire) begin
          idx_d = '0;
          if (ext_cnt != '0) begin
            state_d = ST_IMM;
            rem_d   = ext_cnt;
          end else begin
            state_d = ST_HOLD;
          end
        end
        ST_IMM: if (fire) begin
          rem_d = rem_q - CNT_W'(1);
          idx_d = idx_q + IDX_W'(1);
          if (rem_q == CNT_W'(1)) state_d = ST_HOLD;
        end
        ST_HOLD: if (take) state_d = ST_FIRST;
        default: state_d = ST_FIRST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FIRST;
      rem_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      idx_q   <= idx_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/framer_fields.sv
module framer_fields
  import framer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  fr_state_e         state,
  input  logic [IDX_W-1:0]  idx,
  input  logic              is_pfx,
  input  logic [BYTE_W-1:0] byte_i,
  output fr_insn_t          insn_o
);
  logic              ext_q;
  logic [BYTE_W-1:0] pfx_q, disp_q, opc_q;
  logic [LEN_W-1:0]  len_q;
  logic [BYTE_W-1:0] imm_q [IMM_BYTES];

  wire start = fire && (state == ST_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      pfx_q  <= '0;
      disp_q <= '0;
      opc_q  <= '0;
      len_q  <= '0;
    end else if (start) begin
      ext_q  <= is_pfx;
      pfx_q  <= is_pfx ? byte_i : '0;
      opc_q  <= is_pfx ? '0 : byte_i;
      disp_q <= '0;
      len_q  <= LEN_W'(1);
    end else if (fire) begin
      len_q <= len_q + LEN_W'(1);
      if (state == ST_DISP) disp_q <= byte_i;
      if (state == ST_OP)   opc_q  <= byte_i;
    end
  end

  for (genvar g = 0; g < IMM_BYTES; g++) begin : g_imm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        imm_q[g] <= '0;
      else if (start)
        imm_q[g] <= '0;
      else if (fire && state == ST_IMM && idx == IDX_W'(g))
        imm_q[g] <= byte_i;
    end
  end

  always_comb begin
    insn_o.ext  = ext_q;
    insn_o.pfx  = pfx_q;
    insn_o.disp = disp_q;
    insn_o.opc  = opc_q;
    insn_o.len  = len_q;
    for (int i = 0; i < IMM_BYTES; i++) insn_o.imm[i*BYTE_W +: BYTE_W] = imm_q[i];
  end
endmodule

// File: rtl/insn_framer.sv
module insn_framer
  import framer_pkg::*;
#(
  parameter logic [7:0] PFX_FIRST = 8'hE0,
  parameter logic [7:0] PFX_LAST  = 8'hFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_ext,
  output logic [7:0]  out_prefix,
  output logic [7:0]  out_disp,
  output logic [7:0]  out_opcode,
  output logic [15:0] out_imm,
  output logic [2:0]  out_len
);
  fr_state_e        state;
  logic [IDX_W-1:0] idx;
  logic             is_pfx;
  logic [CNT_W-1:0] pfx_cnt, ext_cnt, base_cnt;
  fr_insn_t         insn;
  logic             fire, take;

  assign in_ready  = (state != ST_HOLD);
  assign out_valid = (state == ST_HOLD);
  assign fire      = in_valid && in_ready && !flush;
  assign take      = out_valid && out_ready;

  framer_len_lut #(.PFX_FIRST(PFX_FIRST), .PFX_LAST(PFX_LAST)) lut_i (
    .byte_i    (in_data),
    .is_pfx_o  (is_pfx),
    .pfx_cnt_o (pfx_cnt),
    .ext_cnt_o (ext_cnt),
    .base_cnt_o(base_cnt)
  );

  framer_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .fire    (fire),
    .take    (take),
    .is_pfx  (is_pfx),
    .pfx_cnt (pfx_cnt),
    .ext_cnt (ext_cnt),
    .base_cnt(base_cnt),
    .state_o (state),
    .idx_o   (idx)
  );

  framer_fields fields_i (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .state (state),
    .idx   (idx),
    .is_pfx(is_pfx),
    .byte_i(in_data),
    .insn_o(insn)
  );

  assign out_ext    = insn.ext;
  assign out_prefix = insn.pfx;
  assign out_disp   = insn.disp;
  assign out_opcode = insn.opc;
  assign out_imm    = insn.imm;
  assign out_len    = insn.len;
endmodule

// File: rtl/insn_framer_chk.sv
module insn_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_ext,
  input logic [7:0]  out_prefix,
  input logic [7:0]  out_disp,
  input logic [7:0]  out_opcode,
  input logic [15:0] out_imm,
  input logic [2:0]  out_len
);
  AST_HOLD_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R8

  AST_TAKE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !flush) |=> (!out_valid && in_ready)); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_ext) &&
      $stable(out_prefix) && $stable(out_disp) && $stable(out_opcode) &&
      $stable(out_imm) && $stable(out_len))); // R7

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd5)); // R5

  AST_BASIC_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ext) |-> (out_len <= 3'd3)); // R2

  AST_BASIC_NO_PFX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ext) |-> (out_prefix == 8'h00 && out_disp == 8'h00)); // R5

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && in_ready)); // R9
endmodule

bind insn_framer insn_framer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_ext   (out_ext),
  .out_prefix(out_prefix),
  .out_disp  (out_disp),
  .out_opcode(out_opcode),
  .out_imm   (out_imm),
  .out_len   (out_len)
);

// File: tb/insn_framer_tb_top.sv
module insn_framer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_ext;
  logic [7:0]  out_prefix, out_disp, out_opcode;
  logic [15:0] out_imm;
  logic [2:0]  out_len;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  insn_framer dut_i (.*);

  // {ext, prefix, disp, opcode, imm, len}
  typedef logic [43:0] exp_t;
  exp_t       exp_q[$];
  logic [7:0] stream_q[$];

  function automatic exp_t model(input logic [7:0] b [5]);
    logic ext; logic [7:0] p, d, o; logic [15:0] im; int pos, n;
    p = 0; d = 0; im = 0; pos = 1; n = 0;
    ext = (b[0] >= 8'hE0) && (b[0] <= 8'hFE);                      // R2
    if (ext) begin
      p = b[0];
      if (b[0][3:0] >= 4'd4 && b[0][3:0] <= 4'd7) begin d = b[1]; pos = 2; end // R3
      o = b[pos]; pos++;
      if (o >= 8'h68 && o <= 8'h6F) n = 1;                          // R4
      else if (o >= 8'h38 && o <= 8'h3F) n = 2;
    end else begin
      o = b[0];
      if (o >= 8'h20 && o <= 8'h3F) n = 1;
      else if (o >= 8'h40 && o <= 8'h4F) n = 2;
    end
    for (int i = 0; i < n; i++) im[8*i +: 8] = b[pos+i];
    return {ext, p, d, o, im, 3'(pos + n)};
  endfunction

  function automatic exp_t actual();
    return {out_ext, out_prefix, out_disp, out_opcode, out_imm, out_len};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic push_insn(input logic [7:0] b [5], output exp_t e);
    e = model(b);
    for (int i = 0; i < int'(e[2:0]); i++) stream_q.push_back(b[i]);
  endtask

  task automatic directed(input logic [7:0] b [5], input string req);
    exp_t e;
    e = model(b);
    for (int i = 0; i < int'(e[2:0]); i++) send_byte(b[i]);
    chk(out_valid && !in_ready, {req, "/R8 framed"}, {out_valid, in_ready}, 2'b10);
    chk(actual() == e, req, actual(), e);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R8 release", {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b [5];
    exp_t e, last;
    int ninsn, got, seed;
    bit  held;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R1 reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);

    // R6 worked example
    b = '{8'hF4, 8'h7F, 8'h68, 8'h05, 8'h00};
    chk(model(b) == {1'b1, 8'hF4, 8'h7F, 8'h68, 16'h0005, 3'd4}, "R6 model", model(b), 0);
    directed(b, "R6");
    // window edges, R2
    b = '{8'hDF, 8'h11, 8'h22, 8'h33, 8'h44}; directed(b, "R2 DF basic");
    b = '{8'hFF, 8'h11, 8'h22, 8'h33, 8'h44}; directed(b, "R2 FF basic");
    b = '{8'hE0, 8'h00, 8'h22, 8'h33, 8'h44}; directed(b, "R2 E0 ext");
    b = '{8'hFE, 8'h6A, 8'h9C, 8'h33, 8'h44}; directed(b, "R4 FE ext imm8");
    b = '{8'h45, 8'hCD, 8'hAB, 8'h33, 8'h44}; directed(b, "R5 basic imm16");
    b = '{8'h2A, 8'h5A, 8'h22, 8'h33, 8'h44}; directed(b, "R2 basic imm8");
    // R3/R4 longest form: zero-page prefix, imm16 operation, length 5
    b = '{8'hF7, 8'h80, 8'h3C, 8'h34, 8'h12}; directed(b, "R5 len5");
    chk(model(b) == {1'b1, 8'hF7, 8'h80, 8'h3C, 16'h1234, 3'd5}, "R5 len5 model", model(b), 0);
    b = '{8'hE4, 8'h01, 8'h10, 8'h33, 8'h44}; directed(b, "R3 E4 disp");
    b = '{8'hE8, 8'h39, 8'hEF, 8'hBE, 8'h44}; directed(b, "R3 E8 nodisp");

    // R9 flush partial instruction
    send_byte(8'hF4); send_byte(8'h7F);
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    chk(!out_valid && in_ready, "R9 flush partial", {out_valid, in_ready}, 2'b01);
    b = '{8'h00, 8'h11, 8'h22, 8'h33, 8'h44}; directed(b, "R9 restart");

    // R7/R8 hold with offered byte, then R9 flush of held insn
    b = '{8'h07, 8'h11, 8'h22, 8'h33, 8'h44};
    send_byte(8'h07);
    e = model(b);
    in_valid = 1'b1; in_data = 8'h99;
    repeat (4) @(negedge clk);
    chk(out_valid && !in_ready, "R8 stall", {out_valid, in_ready}, 2'b10);
    chk(actual() == e, "R7 held fields", actual(), e);
    in_valid = 1'b0; flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    chk(!out_valid && in_ready, "R9 flush held", {out_valid, in_ready}, 2'b01);
    b = '{8'h30, 8'h77, 8'h22, 8'h33, 8'h44}; directed(b, "R9 next first byte");

    // constrained random with gaps and back-pressure
    ninsn = 400;
    for (int k = 0; k < ninsn; k++) begin
      for (int i = 0; i < 5; i++) b[i] = 8'($urandom);
      case ($urandom % 4)
        0: b[0] = 8'hE0 + 8'($urandom % 31);
        1: begin b[0] = 8'hE0 + 8'($urandom % 31); b[1] = 8'h68 | 8'($urandom % 8); b[2] = b[1]; end
        2: begin b[0] = 8'hE0 + 8'($urandom % 31); b[1] = 8'h38 | 8'($urandom % 8); b[2] = b[1]; end
        default: if (b[0] >= 8'hE0 && b[0] <= 8'hFE) b[0] = 8'($urandom % 8'h50);
      endcase
      push_insn(b, e);
      exp_q.push_back(e);
    end
    got = 0; held = 0; last = 0;
    fork
      begin
        while (stream_q.size() > 0) begin
          if ($urandom % 4 == 0) @(negedge clk);
          send_byte(stream_q.pop_front());
        end
      end
      begin
        while (got < ninsn) begin
          @(negedge clk);
          if (out_valid) begin
            if (!held) begin
              e = exp_q[0];
              chk(actual() == e, "R2/R3/R4/R5 random insn", actual(), e);
              chk(!in_ready, "R8 random stall", in_ready, 0);
              last = actual(); held = 1;
            end else begin
              chk(actual() == last, "R7 random stable", actual(), last);
            end
          end
          out_ready = ($urandom % 3 != 0);
          if (out_valid && out_ready) begin
            void'(exp_q.pop_front()); got++; held = 0;
          end
        end
        @(negedge clk); out_ready = 1'b0;
      end
    join
    chk(!out_valid && in_ready, "R8 drained", {out_valid, in_ready}, 2'b01);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule